// File: doc/BRIEF.md
# Burst-of-Two Split-Port SRAM

This block is a synchronous on-chip memory with a read data bus and a separate write data bus. Reads and writes can run at the same time. One address bus is shared by the two ports. The block runs on a single fabric clock at twice the base rate, and an internal slot flag alternates between a read slot and a write slot on each fabric edge. In a read slot the shared bus is taken as a read address. In a write slot it is taken as a write address. Each address holds a pair of words, and every access moves both words as a two-beat burst. Because the read and write data buses are separate, no bus turnaround is ever needed.

All inputs are registered on entry and read data leaves through an output register. When a read and a write hit the same address close together in time, the read is served from the write's own beats, so it always returns the newest data. Each port has an active-low select. A port that is not selected ignores the address bus in its slot.

Top module: `burst2_dp_sram`

## Requirements
- R1: While reset is high, and on the edge after it, rvalid is 0 and rdata is 0.
- R2: The first fabric edge after reset is released is a read slot, and the slots alternate after that. A read starts only in a read slot with rd_sel_n low. A write starts only in a write slot with wr_sel_n low. A select that is low in the other port's slot has no effect.
- R3: When a read address is captured at edge E, the lower word of the pair is on rdata with rvalid high after edge E+3, and the upper word is there after edge E+4.
- R4: When a write address is captured at edge F, wdata sampled at edge F+1 becomes the lower word (returned first) and wdata sampled at edge F+2 becomes the upper word.
- R5: A written pair stays stored and is returned by any later read of that address.
- R6: A read of one address and a write of another address in the same base cycle both complete correctly.
- R7: A read that hits the address of a write captured one edge later (the same base cycle) returns that write's two beats.
- R8: A read that hits the address of a write captured one edge earlier (the previous base cycle) returns that write's two beats.
- R9: When no read beat is due, rvalid is 0 and rdata holds its last value. A read slot with rd_sel_n high produces no beats.
- R10: A write slot with wr_sel_n high leaves memory unchanged, whatever is on addr and wdata.
- R11: Reads issued in consecutive base cycles give an unbroken stream of beats with rvalid held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock at twice the base rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Read port select, active low, sampled in read slots |
| wr_sel_n | input | 1 | Write port select, active low, sampled in write slots |
| addr | input | ADDR_W | Shared address of a word pair |
| wdata | input | WORD_W | Write data beats |
| rdata | output | WORD_W | Registered read data beats |
| rvalid | output | 1 | High on each cycle that carries a read beat |

## Verification
The bench targets reads that overlap writes to the same address, one edge before and one edge after. A design without forwarding would return stale or undefined pairs in those cases. It also targets a read that hits both kinds of write at once, where the newest write must win. Deselected reads and writes are checked as well: if a port ignored its select, the bench would see extra beats or a later read returning junk data. Beat order and the exact latency are checked on every edge, so swapped words, a one-cycle shift or a gap in back-to-back streams all show up as mismatches. Finally, reset is applied in the middle of a pending read: the read must vanish, and the slot sequence must restart with a read slot.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

    // Address-bus slot owned by each fabric edge
    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;

    // Source of the next output beat
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_LO   = 2'd1,
        OUT_HI   = 2'd2
    } out_sel_e;

    // Edges between write-address capture and the second data beat
    localparam int unsigned WR_ALIGN = 2;

    function automatic slot_e slot_after(input slot_e s);
        return (s == SLOT_RD) ? SLOT_WR : SLOT_RD;
    endfunction

endpackage

// File: rtl/b2s_capture.sv
module b2s_capture
    import b2s_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output slot_e         slot_q,
    output logic          rd_req_q,
    output logic          wr_req_q,
    output logic [AW-1:0] addr_q,
    output logic [W-1:0]  din_q
);

    // Input register stage; slot_q names the slot of the coming edge (R2)
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SLOT_RD;
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            addr_q   <= '0;
            din_q    <= '0;
        end else begin
            slot_q   <= slot_after(slot_q);
            rd_req_q <= (slot_q == SLOT_RD) && !rd_sel_n;
            wr_req_q <= (slot_q == SLOT_WR) && !wr_sel_n;
            addr_q   <= addr;
            din_q    <= wdata;
        end
    end

endmodule

// File: rtl/b2s_wr_pipe.sv
module b2s_wr_pipe
    import b2s_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req_q,
    input  logic [AW-1:0]   addr_q,
    input  logic [W-1:0]    din_q,
    output logic            commit_en,
    output logic [AW-1:0]   commit_addr,
    output logic [2*W-1:0]  commit_data
);

    localparam int STAGES = WR_ALIGN;

    logic          v_w [STAGES+1];
    logic [AW-1:0] a_w [STAGES+1];
    logic [W-1:0]  lo_q;

    assign v_w[0] = wr_req_q;
    assign a_w[0] = addr_q;

    // Carry the write address along until both beats have arrived (R4)
    for (genvar s = 0; s < STAGES; s++) begin : g_align
        logic          v_r;
        logic [AW-1:0] a_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_r <= 1'b0;
                a_r <= '0;
            end else begin
                v_r <= v_w[s];
                a_r <= a_w[s];
            end
        end
        assign v_w[s+1] = v_r;
        assign a_w[s+1] = a_r;
    end

    // First beat parked while the second is registered
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (v_w[STAGES-1]) begin
            lo_q <= din_q;
        end
    end

    assign commit_en   = v_w[STAGES];
    assign commit_addr = a_w[STAGES];
    assign commit_data = {din_q, lo_q};

endmodule

// File: rtl/b2s_store.sv
module b2s_store #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/b2s_rd_pipe.sv
module b2s_rd_pipe
    import b2s_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_req_q,
    input  logic            wr_req_q,
    input  logic [AW-1:0]   addr_q,
    input  logic [W-1:0]    din_q,
    input  logic            commit_en,
    input  logic [AW-1:0]   commit_addr,
    input  logic [2*W-1:0]  commit_data,
    output logic [AW-1:0]   look_addr,
    input  logic [2*W-1:0]  look_data,
    output logic [W-1:0]    rdata,
    output logic            rvalid
);

    typedef struct packed {
        logic           vld;
        logic           late;
        logic [2*W-1:0] pair;
    } fetch_t;

    typedef struct packed {
        logic         vld;
        logic         late;
        logic [W-1:0] hi;
    } tail_t;

    logic          rv2_q;
    logic [AW-1:0] ra2_q;
    fetch_t        s3_q;
    tail_t         s4_q;
    logic [W-1:0]  rdata_q;
    logic          rvalid_q;
    out_sel_e      osel;
    logic          early_hit;
    logic          late_hit;

    assign look_addr = ra2_q;

    // Previous-cycle write still in flight to the array (R8)
    assign early_hit = commit_en && (commit_addr == ra2_q);
    // Same-cycle write, address captured one edge after the read (R7)
    assign late_hit  = rv2_q && wr_req_q && (addr_q == ra2_q);

    always_comb begin
        if (s3_q.vld)      osel = OUT_LO;
        else if (s4_q.vld) osel = OUT_HI;
        else               osel = OUT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv2_q    <= 1'b0;
            ra2_q    <= '0;
            s3_q     <= '0;
            s4_q     <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rv2_q     <= rd_req_q;
            ra2_q     <= addr_q;
            s3_q.vld  <= rv2_q;
            s3_q.late <= late_hit;
            s3_q.pair <= early_hit ? commit_data : look_data;
            s4_q.vld  <= s3_q.vld;
            s4_q.late <= s3_q.late;
            s4_q.hi   <= s3_q.pair[2*W-1:W];
            // Output register: lower beat, then upper beat, else hold (R3, R9)
            case (osel)
                OUT_LO: begin
                    rdata_q  <= s3_q.late ? din_q : s3_q.pair[W-1:0];
                    rvalid_q <= 1'b1;
                end
                OUT_HI: begin
                    rdata_q  <= s4_q.late ? din_q : s4_q.hi;
                    rvalid_q <= 1'b1;
                end
                default: begin
                    rvalid_q <= 1'b0;
                end
            endcase
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

endmodule

// File: rtl/burst2_dp_sram.sv
module burst2_dp_sram
    import b2s_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam int PAIR_W = 2 * WORD_W;

    slot_e              slot_now;
    logic               rd_req_q;
    logic               wr_req_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  din_q;
    logic               commit_en;
    logic [ADDR_W-1:0]  commit_addr;
    logic [PAIR_W-1:0]  commit_data;
    logic [ADDR_W-1:0]  look_addr;
    logic [PAIR_W-1:0]  look_data;
    logic               slot_wr;

    assign slot_wr = (slot_now == SLOT_WR);

    b2s_capture #(.AW(ADDR_W), .W(WORD_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .slot_q   (slot_now),
        .rd_req_q (rd_req_q),
        .wr_req_q (wr_req_q),
        .addr_q   (addr_q),
        .din_q    (din_q)
    );

    b2s_wr_pipe #(.AW(ADDR_W), .W(WORD_W)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .wr_req_q    (wr_req_q),
        .addr_q      (addr_q),
        .din_q       (din_q),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    b2s_store #(.AW(ADDR_W), .DW(PAIR_W)) u_mem (
        .clk   (clk),
        .we    (commit_en),
        .waddr (commit_addr),
        .wdata (commit_data),
        .raddr (look_addr),
        .rdata (look_data)
    );

    b2s_rd_pipe #(.AW(ADDR_W), .W(WORD_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_req_q    (rd_req_q),
        .wr_req_q    (wr_req_q),
        .addr_q      (addr_q),
        .din_q       (din_q),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .look_addr   (look_addr),
        .look_data   (look_data),
        .rdata       (rdata),
        .rvalid      (rvalid)
    );

endmodule

// File: rtl/b2s_chk.sv
module b2s_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_sel_n,
    input logic         slot_is_wr,
    input logic [W-1:0] rdata,
    input logic         rvalid
);

    logic rd_go;
    assign rd_go = !rst && !slot_is_wr && !rd_sel_n;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!rvalid && rdata == '0));

    p_slot_rd_then_wr_r2: assert property (@(posedge clk) disable iff (rst)
        !slot_is_wr |=> slot_is_wr);

    p_slot_wr_then_rd_r2: assert property (@(posedge clk) disable iff (rst)
        slot_is_wr |=> !slot_is_wr);

    p_read_two_beats_r3: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> ##3 rvalid ##1 rvalid);

    p_beat_has_request_r9: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(rd_go, 4) || $past(rd_go, 5)));

    p_idle_holds_data_r9: assert property (@(posedge clk) disable iff (rst)
        (!rvalid && !$past(rst)) |-> $stable(rdata));

endmodule

bind burst2_dp_sram b2s_chk #(.W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_sel_n   (rd_sel_n),
    .slot_is_wr (slot_wr),
    .rdata      (rdata),
    .rvalid     (rvalid)
);

// File: tb/burst2_dp_sram_test.sv
module burst2_dp_sram_test;

    localparam int W    = 18;
    localparam int AW   = 6;
    localparam int NEXP = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;

    always #4 clk = ~clk;   // 125 MHz

    burst2_dp_sram #(.WORD_W(W), .ADDR_W(AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    // One entry per base cycle: read in its read slot, write in its write slot
    typedef struct packed {
        logic          rd;
        logic [AW-1:0] ra;
        logic          wr;
        logic [AW-1:0] wa;
        logic [W-1:0]  d0;
        logic [W-1:0]  d1;
        logic [3:0]    tag;
    } op_t;

    localparam int NOPS = 17;
    localparam op_t OPS [NOPS] = '{
        '{1'b0, 6'd0, 1'b1, 6'd3, 18'h11111, 18'h22222, 4'd4},  // R4 fill 3
        '{1'b0, 6'd0, 1'b1, 6'd5, 18'h0aaaa, 18'h35555, 4'd4},  // R4 fill 5
        '{1'b1, 6'd3, 1'b1, 6'd7, 18'h3c3c3, 18'h0f0f0, 4'd6},  // R6 read 3 while writing 7
        '{1'b1, 6'd7, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd8},  // R8 previous-cycle write
        '{1'b1, 6'd9, 1'b1, 6'd9, 18'h12345, 18'h2abcd, 4'd7},  // R7 same-cycle write
        '{1'b1, 6'd9, 1'b0, 6'd9, 18'h3ffff, 18'h3ffff, 4'd8},  // R8 + R10 deselected junk write
        '{1'b0, 6'd0, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd9},
        '{1'b1, 6'd9, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd10}, // R10 location 9 unchanged
        '{1'b0, 6'd5, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd9},  // R9 deselected read
        '{1'b1, 6'd5, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd5},  // R5 stored pair
        '{1'b1, 6'd3, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd11}, // R11 back to back
        '{1'b1, 6'd7, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd11}, // R11 back to back
        '{1'b1, 6'd5, 1'b1, 6'd3, 18'h01234, 18'h04321, 4'd3},  // R3 latency and order
        '{1'b1, 6'd3, 1'b1, 6'd3, 18'h2f00d, 18'h1beef, 4'd7},  // R7 newest of two writes wins
        '{1'b1, 6'd3, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd8},  // R8
        '{1'b0, 6'd0, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd9},
        '{1'b0, 6'd0, 1'b0, 6'd0, 18'h00000, 18'h00000, 4'd9}
    };

    int            checks = 0;
    int            errors = 0;
    int            edge_k = 0;
    logic          exp_v [NEXP];
    logic [W-1:0]  exp_d [NEXP];
    int            exp_t [NEXP];
    logic [2*W-1:0] model [1 << AW];
    logic [W-1:0]  last_d = '0;
    logic [W-1:0]  pd0 = '0;
    logic [W-1:0]  pd1 = '0;

    task automatic chk(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    // Compare the outputs left by the latest edge with the expected schedule
    task automatic step();
        string rq;
        @(posedge clk);
        @(negedge clk);
        if (exp_v[edge_k]) begin
            rq = $sformatf("R%0d", exp_t[edge_k]);
            chk(rvalid === 1'b1, rq, W'(rvalid), W'(1));
            chk(rdata === exp_d[edge_k], rq, rdata, exp_d[edge_k]);
            last_d = exp_d[edge_k];
        end else begin
            // R9: no beat due, data held
            chk(rvalid === 1'b0, "R9", W'(rvalid), W'(0));
            chk(rdata === last_d, "R9", rdata, last_d);
        end
        edge_k++;
    endtask

    task automatic run_op(input op_t op);
        if (op.wr) model[op.wa] = {op.d1, op.d0};
        if (op.rd) begin
            exp_v[edge_k+3] = 1'b1;
            exp_d[edge_k+3] = model[op.ra][W-1:0];
            exp_t[edge_k+3] = int'(op.tag);
            exp_v[edge_k+4] = 1'b1;
            exp_d[edge_k+4] = model[op.ra][2*W-1:W];
            exp_t[edge_k+4] = int'(op.tag);
        end
        // Read slot: write select held low to show it is ignored here (R2)
        addr     = op.ra;
        rd_sel_n = !op.rd;
        wr_sel_n = 1'b0;
        wdata    = pd0;
        step();
        // Write slot: read select held low to show it is ignored here (R2)
        addr     = op.wa;
        rd_sel_n = 1'b0;
        wr_sel_n = !op.wr;
        wdata    = pd1;
        step();
        pd0 = op.d0;
        pd1 = op.d1;
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle outputs under reset
        chk(rvalid === 1'b0, "R1", W'(rvalid), W'(0));
        chk(rdata === '0, "R1", rdata, '0);
        for (int i = 0; i < NEXP; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
            exp_t[i] = 9;
        end
        edge_k = 0;
        last_d = '0;
        pd0    = '0;
        pd1    = '0;
        rst    = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL all requirements: watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        for (int n = 0; n < NOPS; n++) begin
            run_op(OPS[n]);
        end

        // Reset while a read is in flight: the read must vanish (R1)
        run_op('{1'b1, 6'd9, 1'b0, 6'd0, 18'h0, 18'h0, 4'd1});
        do_reset();
        @(negedge clk);
        chk(rvalid === 1'b0, "R1", W'(rvalid), W'(0));
        chk(rdata === '0, "R1", rdata, '0);
        edge_k = 0;

        // R2: first edge after release is a read slot again; memory kept
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_op('{1'b1, 6'd3, 1'b0, 6'd0, 18'h0, 18'h0, 4'd2});
        run_op('{1'b0, 6'd0, 1'b0, 6'd0, 18'h0, 18'h0, 4'd9});
        run_op('{1'b0, 6'd0, 1'b0, 6'd0, 18'h0, 18'h0, 4'd9});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule